// File: doc/BRIEF.md
# Reference-Counting Write-Back Cache

This block is a small two-way set-associative write-back cache. Each line carries a dirty bit, and each set carries one LRU bit. It also feeds a separate reference-count engine with a stream of commands. A requester issues loads, plain stores and reference stores over a valid/ready port. On a reference store the cache reads the word that is about to be overwritten and writes the new word in the same cycle. It then queues a decrement carrying the old reference and an increment carrying the new one.

Every time a line is filled from memory, the cache queues a tag-update command that carries the line's base address. The reference-count side can send a clean request when it finds that a line holds only dead storage. The cache serves that request when no access is waiting. If the line is still resident, the cache clears its dirty bit and marks it as the victim of its set, so the line is later dropped without a write-back.

Commands leave through a small FIFO with a valid/ready output. The backing store is reached over a line-wide request port that is held until the memory acknowledges it.

Top module: `refcache_top`

## Requirements
- R1: A load returns the current value of the addressed word (`req_op` = 0), with `resp_valid` high in the cycle after acceptance. That value is the latest stored value, or the memory contents if the word has not been stored. A plain store (`req_op` = 1) writes the word and marks the line dirty.
- R2: A reference store (`req_op` = 2) writes the word and queues two commands, in this order: a decrement (kind 2) carrying the word's previous value, then an increment (kind 1) carrying the stored value.
- R3: A reference value of zero produces no command. A zero old value produces no decrement, and a zero new value produces no increment. No command is issued other than those named in R2 and R4.
- R4: Each line fill queues one tag-update command (kind 3) carrying the line base address, which is the word address with its offset bit cleared. This command is queued ahead of any command from the access that caused the fill.
- R5: When a miss selects a dirty victim, the whole victim line is written back (`mem_write` = 1) before the fill read. A clean victim causes no write-back. Memory contents always equal the values of the lines that were written back.
- R6: A clean request for a resident line clears its dirty bit and makes it the LRU way of its set. The next miss in that set therefore replaces it without a write-back, and the other way stays resident.
- R7: A clean request whose tag matches no way in its set changes nothing. A dirty line in that set is still written back when it is evicted.
- R8: A reference store is accepted only when the command FIFO has two free slots. While the FIFO lacks room, `req_ready` stays low and no command is lost or reordered.
- R9: After reset no line is valid, and `cmd_valid`, `mem_valid` and `resp_valid` are low. On a miss the cache fills an invalid way first (way 0 before way 1); otherwise it fills the LRU way. An access makes the other way LRU.
- R10: Once `mem_valid` is raised, it stays high with `mem_addr` and `mem_write` unchanged until `mem_ready` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request valid; held with its fields until accepted |
| req_ready | output | 1 | Access accepted this cycle (hit, and FIFO room for a reference store) |
| req_op | input | 2 | 0 load, 1 store, 2 reference store |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Store data |
| resp_valid | output | 1 | Load data valid |
| resp_rdata | output | DATA_W | Load data |
| cln_valid | input | 1 | Clean request valid |
| cln_ready | output | 1 | Clean request taken (idle, no access pending) |
| cln_addr | input | ADDR_W | Any word address within the line to clean |
| mem_valid | output | 1 | Memory request valid |
| mem_write | output | 1 | 1 for a write-back, 0 for a fill read |
| mem_addr | output | ADDR_W | Line base address |
| mem_wline | output | DATA_W*LINE_WORDS | Write-back line, word 0 in the low bits |
| mem_ready | input | 1 | Memory completes the request this cycle |
| mem_rline | input | DATA_W*LINE_WORDS | Fill line, valid with mem_ready |
| cmd_valid | output | 1 | Command available |
| cmd_ready | input | 1 | Command consumed |
| cmd_kind | output | 2 | 1 increment, 2 decrement, 3 tag update |
| cmd_data | output | max(DATA_W,ADDR_W) | Reference value or line address |

## Verification
On every cycle, the assertions check that the memory request is held steady until it is acknowledged and that the FIFO never receives more pushes than it has free slots. They also check that no increment or decrement ever carries zero, that a completed fill is followed by a visible command, that an accepted load produces a response, and that a set's LRU bit is never both touched and demoted in the same cycle. Other behaviours need whole access sequences and can only be shown by the bench's scenarios. These are the order of decrement and increment, the choice of victim and the write-back decision, the effect of a clean request on a later eviction, the dropping of a non-resident clean, and the absence of loss while a stalled reference store waits. The bench runs these sequences against an arithmetic model of the sets and the memory image.

// File: rtl/refc_pkg.sv
package refc_pkg;
  typedef enum logic [1:0] {OP_LOAD = 2'd0, OP_STORE = 2'd1, OP_REFST = 2'd2} op_e;
  typedef enum logic [1:0] {CMD_INC = 2'd1, CMD_DEC = 2'd2, CMD_TAG = 2'd3} cmd_e;
  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_WB = 2'd1, ST_FILL = 2'd2} st_e;
endpackage

// File: rtl/refc_cmd_fifo.sv
module refc_cmd_fifo #(
  parameter int W     = 10,
  parameter int DEPTH = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push_a,
  input  logic [W-1:0]               data_a,
  input  logic                       push_b,
  input  logic [W-1:0]               data_b,
  input  logic                       pop,
  output logic [W-1:0]               head,
  output logic                       not_empty,
  output logic [$clog2(DEPTH+1)-1:0] free_cnt
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH+1);

  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, wr_d, rd_q, rd_d, wr_b;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    wr_b  = wr_q + PTR_W'(push_a);
    wr_d  = wr_q + PTR_W'(push_a) + PTR_W'(push_b);
    rd_d  = rd_q + PTR_W'(pop);
    cnt_d = cnt_q + CNT_W'(push_a) + CNT_W'(push_b) - CNT_W'(pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_a) mem_q[wr_q] <= data_a;
    if (push_b) mem_q[wr_b] <= data_b;
  end

  assign head      = mem_q[rd_q];
  assign not_empty = (cnt_q != '0);
  assign free_cnt  = CNT_W'(DEPTH) - cnt_q;

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (CNT_W'(push_a) + CNT_W'(push_b)) <= free_cnt);
  // R8
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> not_empty);
endmodule

// File: rtl/refc_lru.sv
module refc_lru #(
  parameter int SETS  = 2,
  parameter int IDX_W = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             touch_en,
  input  logic [IDX_W-1:0] touch_idx,
  input  logic             touch_way,
  input  logic             demote_en,
  input  logic [IDX_W-1:0] demote_idx,
  input  logic             demote_way,
  output logic [SETS-1:0]  lru_way
);
  logic [SETS-1:0] lru_q, lru_d;

  for (genvar s = 0; s < SETS; s++) begin : g_set
    always_comb begin
      lru_d[s] = lru_q[s];
      if (touch_en && touch_idx == IDX_W'(s))
        lru_d[s] = ~touch_way;
      else if (demote_en && demote_idx == IDX_W'(s))
        lru_d[s] = demote_way;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lru_q <= '0;
    else        lru_q <= lru_d;
  end

  assign lru_way = lru_q;

  // R6
  lru_single_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(touch_en && demote_en));
endmodule

// File: rtl/refcache_top.sv
module refcache_top import refc_pkg::*; #(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 8,
  parameter int SETS       = 2,
  parameter int LINE_WORDS = 2,
  parameter int FIFO_DEPTH = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         req_valid,
  output logic                         req_ready,
  input  logic [1:0]                   req_op,
  input  logic [ADDR_W-1:0]            req_addr,
  input  logic [DATA_W-1:0]            req_wdata,
  output logic                         resp_valid,
  output logic [DATA_W-1:0]            resp_rdata,
  input  logic                         cln_valid,
  output logic                         cln_ready,
  input  logic [ADDR_W-1:0]            cln_addr,
  output logic                         mem_valid,
  output logic                         mem_write,
  output logic [ADDR_W-1:0]            mem_addr,
  output logic [DATA_W*LINE_WORDS-1:0] mem_wline,
  input  logic                         mem_ready,
  input  logic [DATA_W*LINE_WORDS-1:0] mem_rline,
  output logic                         cmd_valid,
  input  logic                         cmd_ready,
  output logic [1:0]                   cmd_kind,
  output logic [((DATA_W > ADDR_W) ? DATA_W : ADDR_W)-1:0] cmd_data
);
  localparam int IDX_W  = $clog2(SETS);
  localparam int OFF_W  = $clog2(LINE_WORDS);
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
  localparam int LINE_W = DATA_W * LINE_WORDS;
  localparam int PAY_W  = (DATA_W > ADDR_W) ? DATA_W : ADDR_W;
  localparam int CMD_W  = 2 + PAY_W;
  localparam int CNT_W  = $clog2(FIFO_DEPTH + 1);

  st_e              state_q, state_d;
  logic             vic_q, vic_d;
  logic [1:0]       valid_q [SETS];
  logic [1:0]       valid_d [SETS];
  logic [1:0]       dirty_q [SETS];
  logic [1:0]       dirty_d [SETS];
  logic [TAG_W-1:0] tag_q   [SETS][2];
  logic [LINE_W-1:0] line_q [SETS][2];
  logic             resp_valid_q;
  logic [DATA_W-1:0] resp_rdata_q;

  logic [OFF_W-1:0] r_off;
  logic [IDX_W-1:0] r_idx, c_idx;
  logic [TAG_W-1:0] r_tag, c_tag;
  logic [1:0]       hit_vec, c_hit_vec;
  logic             hit, hit_way, c_way, victim_c;
  logic [SETS-1:0]  lru_way;
  logic [DATA_W-1:0] cur_word;
  logic             is_ref, room1, room2, acc, wr_en, ref_acc, load_acc;
  logic             miss_start, fill_done, cln_apply;
  logic [ADDR_W-1:0] fill_addr;
  logic             push_a, push_b, fifo_ne;
  logic [CMD_W-1:0] data_a, data_b, fifo_head;
  logic [CNT_W-1:0] free_cnt;

  assign r_off = req_addr[OFF_W-1:0];
  assign r_idx = req_addr[OFF_W +: IDX_W];
  assign r_tag = req_addr[ADDR_W-1 -: TAG_W];
  assign c_idx = cln_addr[OFF_W +: IDX_W];
  assign c_tag = cln_addr[ADDR_W-1 -: TAG_W];

  for (genvar w = 0; w < 2; w++) begin : g_way
    assign hit_vec[w]   = valid_q[r_idx][w] && (tag_q[r_idx][w] == r_tag);
    assign c_hit_vec[w] = valid_q[c_idx][w] && (tag_q[c_idx][w] == c_tag);
  end

  assign hit      = |hit_vec;
  assign hit_way  = hit_vec[1];
  assign c_way    = c_hit_vec[1];
  assign victim_c = !valid_q[r_idx][0] ? 1'b0 :
                    !valid_q[r_idx][1] ? 1'b1 : lru_way[r_idx];
  assign cur_word = line_q[r_idx][hit_way][int'(r_off)*DATA_W +: DATA_W];

  assign is_ref     = (req_op == OP_REFST);
  assign room1      = (free_cnt >= CNT_W'(1));
  assign room2      = (free_cnt >= CNT_W'(2));
  assign req_ready  = (state_q == ST_IDLE) && hit && (!is_ref || room2);
  assign acc        = req_valid && req_ready;
  assign load_acc   = acc && (req_op == OP_LOAD);
  assign wr_en      = acc && (req_op != OP_LOAD);
  assign ref_acc    = acc && is_ref;
  assign miss_start = (state_q == ST_IDLE) && req_valid && !hit;
  assign fill_done  = (state_q == ST_FILL) && room1 && mem_ready;
  assign cln_ready  = (state_q == ST_IDLE) && !req_valid;
  assign cln_apply  = cln_valid && cln_ready && (|c_hit_vec);
  assign fill_addr  = {r_tag, r_idx, {OFF_W{1'b0}}};

  assign mem_valid = (state_q == ST_WB) || ((state_q == ST_FILL) && room1);
  assign mem_write = (state_q == ST_WB);
  assign mem_addr  = (state_q == ST_WB) ? {tag_q[r_idx][vic_q], r_idx, {OFF_W{1'b0}}}
                                        : fill_addr;
  assign mem_wline = line_q[r_idx][vic_q];

  always_comb begin
    state_d = state_q;
    vic_d   = vic_q;
    valid_d = valid_q;
    dirty_d = dirty_q;
    unique case (state_q)
      ST_IDLE: if (miss_start) begin
        vic_d   = victim_c;
        state_d = (valid_q[r_idx][victim_c] && dirty_q[r_idx][victim_c]) ? ST_WB : ST_FILL;
      end
      ST_WB:   if (mem_ready) state_d = ST_FILL;
      ST_FILL: if (fill_done) begin
        state_d               = ST_IDLE;
        valid_d[r_idx][vic_q] = 1'b1;
        dirty_d[r_idx][vic_q] = 1'b0;
      end
      default: state_d = ST_IDLE;
    endcase
    if (wr_en)     dirty_d[r_idx][hit_way] = 1'b1;
    if (cln_apply) dirty_d[c_idx][c_way]   = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      vic_q        <= 1'b0;
      valid_q      <= '{default: '0};
      dirty_q      <= '{default: '0};
      resp_valid_q <= 1'b0;
    end else begin
      state_q      <= state_d;
      vic_q        <= vic_d;
      valid_q      <= valid_d;
      dirty_q      <= dirty_d;
      resp_valid_q <= load_acc;
    end
  end

  always_ff @(posedge clk) begin
    if (load_acc) resp_rdata_q <= cur_word;
    if (wr_en) line_q[r_idx][hit_way][int'(r_off)*DATA_W +: DATA_W] <= req_wdata;
    if (fill_done) begin
      line_q[r_idx][vic_q] <= mem_rline;
      tag_q[r_idx][vic_q]  <= r_tag;
    end
  end

  assign resp_valid = resp_valid_q;
  assign resp_rdata = resp_rdata_q;

  assign push_a = fill_done || (ref_acc && (cur_word != '0));
  assign data_a = fill_done ? {CMD_TAG, PAY_W'(fill_addr)} : {CMD_DEC, PAY_W'(cur_word)};
  assign push_b = ref_acc && (req_wdata != '0);
  assign data_b = {CMD_INC, PAY_W'(req_wdata)};

  refc_cmd_fifo #(.W(CMD_W), .DEPTH(FIFO_DEPTH)) cmdq_i (
    .clk(clk), .rst_n(rst_n),
    .push_a(push_a), .data_a(data_a), .push_b(push_b), .data_b(data_b),
    .pop(cmd_valid && cmd_ready), .head(fifo_head), .not_empty(fifo_ne),
    .free_cnt(free_cnt)
  );

  refc_lru #(.SETS(SETS), .IDX_W(IDX_W)) lru_i (
    .clk(clk), .rst_n(rst_n),
    .touch_en(acc), .touch_idx(r_idx), .touch_way(hit_way),
    .demote_en(cln_apply), .demote_idx(c_idx), .demote_way(c_way),
    .lru_way(lru_way)
  );

  assign cmd_valid = fifo_ne;
  assign {cmd_kind, cmd_data} = fifo_head;

  // R10
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_write)));
  // R3
  null_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_kind != 2'd3) |-> (cmd_data != '0));
  // R4
  tag_after_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_write && mem_ready) |=> cmd_valid);
  // R1
  load_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_op == 2'd0) |=> resp_valid);
endmodule

// File: tb/refcache_top_tb_top.sv
`timescale 1ns/1ps
module refcache_top_tb_top;
  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_ready, resp_valid, cln_valid, cln_ready;
  logic [1:0] req_op, cmd_kind;
  logic [7:0] req_addr, req_wdata, resp_rdata, cln_addr, mem_addr, cmd_data;
  logic mem_valid, mem_write, mem_ready, cmd_valid, cmd_ready;
  logic [15:0] mem_wline, mem_rline;

  always #2 clk = ~clk;

  refcache_top dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .resp_valid(resp_valid), .resp_rdata(resp_rdata),
    .cln_valid(cln_valid), .cln_ready(cln_ready), .cln_addr(cln_addr),
    .mem_valid(mem_valid), .mem_write(mem_write), .mem_addr(mem_addr),
    .mem_wline(mem_wline), .mem_ready(mem_ready), .mem_rline(mem_rline),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_kind(cmd_kind), .cmd_data(cmd_data)
  );

  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  logic [7:0] phys [256];
  logic [7:0] gold [256];
  int wb_n = 0, exp_wb = 0, dly = 0;
  logic [9:0] clog [1024];
  logic [9:0] elog [1024];
  int cn = 0, en = 0, cptr = 0;

  logic       mv [2][2];
  logic       mdty [2][2];
  logic [5:0] mt [2][2];
  logic [7:0] mdat [2][2][2];
  logic       mlru [2];

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // memory responder: acknowledges two cycles after a request appears
  always @(posedge clk) begin
    mem_ready <= 1'b0;
    if (rst_n && mem_valid && !mem_ready) begin
      if (dly == 1) begin
        dly = 0;
        mem_ready <= 1'b1;
        if (mem_write) begin
          phys[mem_addr]      = mem_wline[7:0];
          phys[mem_addr + 1]  = mem_wline[15:8];
          wb_n++;
        end else begin
          mem_rline <= {phys[mem_addr + 1], phys[mem_addr]};
        end
      end else dly++;
    end
  end

  always @(posedge clk) begin
    if (rst_n && cmd_valid && cmd_ready) begin
      clog[cn] = {cmd_kind, cmd_data};
      cn++;
    end
  end

  task automatic mdl(input logic [1:0] op, input logic [7:0] a, input logic [7:0] d);
    logic s; logic [5:0] t; logic o; int w; logic [7:0] old;
    s = a[1]; t = a[7:2]; o = a[0]; w = -1;
    for (int k = 0; k < 2; k++) if (mv[s][k] && mt[s][k] == t) w = k;
    if (w < 0) begin
      w = !mv[s][0] ? 0 : (!mv[s][1] ? 1 : int'(mlru[s]));
      if (mv[s][w] && mdty[s][w]) begin
        gold[{mt[s][w], s, 1'b0}] = mdat[s][w][0];
        gold[{mt[s][w], s, 1'b1}] = mdat[s][w][1];
        exp_wb++;
      end
      mdat[s][w][0] = gold[{t, s, 1'b0}];
      mdat[s][w][1] = gold[{t, s, 1'b1}];
      mt[s][w] = t; mv[s][w] = 1'b1; mdty[s][w] = 1'b0;
      elog[en] = {2'd3, t, s, 1'b0}; en++;
    end
    mlru[s] = (w == 0);
    old = mdat[s][w][o];
    if (op == 2'd2) begin
      if (old != 0) begin elog[en] = {2'd2, old}; en++; end
      if (d != 0)   begin elog[en] = {2'd1, d};   en++; end
    end
    if (op != 2'd0) begin mdat[s][w][o] = d; mdty[s][w] = 1'b1; end
  endtask

  function automatic logic [7:0] mdl_read(input logic [7:0] a);
    logic s; s = a[1];
    for (int k = 0; k < 2; k++)
      if (mv[s][k] && mt[s][k] == a[7:2]) return mdat[s][k][a[0]];
    return gold[a];
  endfunction

  task automatic sync_chk();
    repeat (8) @(negedge clk);
    chk(cn == en, "R3 command count", cn, en);
    chk(wb_n == exp_wb, "R5 write-back count", wb_n, exp_wb);
    for (int i = cptr; i < en && i < cn; i++)
      chk(clog[i] == elog[i], (elog[i][9:8] == 2'd3) ? "R4 tag update" : "R2 ref command",
          int'(clog[i]), int'(elog[i]));
    cptr = (cn > en) ? cn : en;
    cn = cptr; en = cptr;
  endtask

  task automatic cpu(input logic [1:0] op, input logic [7:0] a, input logic [7:0] d,
                     input bit do_sync);
    logic [7:0] expd;
    expd = mdl_read(a);
    mdl(op, a, d);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = a; req_wdata = d;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    req_valid = 1'b0;
    if (op == 2'd0) begin
      chk(resp_valid == 1'b1, "R1 resp_valid", resp_valid, 1);
      chk(resp_rdata == expd, "R1 load data", resp_rdata, expd);
    end
    if (do_sync) sync_chk();
  endtask

  task automatic clean(input logic [7:0] a);
    logic s; s = a[1];
    for (int k = 0; k < 2; k++)
      if (mv[s][k] && mt[s][k] == a[7:2]) begin mdty[s][k] = 1'b0; mlru[s] = k[0]; end
    @(negedge clk);
    cln_valid = 1'b1; cln_addr = a;
    #1;
    while (!cln_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    cln_valid = 1'b0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      chk(1'b0, "watchdog", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    int wb0, c0;
    rst_n = 1'b0; req_valid = 0; req_op = 0; req_addr = 0; req_wdata = 0;
    cln_valid = 0; cln_addr = 0; cmd_ready = 1'b1; mem_ready = 1'b0; mem_rline = '0;
    for (int a = 0; a < 256; a++) begin phys[a] = 8'(a) ^ 8'hA5; gold[a] = 8'(a) ^ 8'hA5; end
    for (int s = 0; s < 2; s++) begin
      mlru[s] = 0;
      for (int w = 0; w < 2; w++) begin mv[s][w] = 0; mdty[s][w] = 0; mt[s][w] = 0; end
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk(cmd_valid == 0, "R9 cmd_valid after reset", cmd_valid, 0);
    chk(mem_valid == 0, "R9 mem_valid after reset", mem_valid, 0);
    chk(resp_valid == 0, "R9 resp_valid after reset", resp_valid, 0);

    // R9: two lines of set 0 fill both ways, the first stays resident
    cpu(2'd0, 8'h00, 8'h00, 1);
    cpu(2'd0, 8'h04, 8'h00, 1);
    c0 = cn;
    cpu(2'd0, 8'h01, 8'h00, 1);
    chk(cn == c0, "R9 invalid way filled first", cn - c0, 0);

    // R1 R4 load sweep
    for (int a = 0; a < 40; a++) cpu(2'd0, 8'(a), 8'h00, 1);

    // R5 dirty evictions
    for (int i = 0; i < 24; i++) cpu(2'd1, 8'(i * 3), 8'(i * 7 + 1), 1);
    for (int a = 0; a < 72; a++) cpu(2'd0, 8'(a), 8'h00, 1);

    // R2 R3 reference store combinations
    cpu(2'd1, 8'h40, 8'h00, 1);
    cpu(2'd2, 8'h40, 8'h00, 1);
    cpu(2'd2, 8'h40, 8'h33, 1);
    cpu(2'd2, 8'h40, 8'h44, 1);
    cpu(2'd2, 8'h40, 8'h00, 1);
    for (int i = 0; i < 24; i++) cpu(2'd2, 8'(8'h80 + i * 5), 8'(i & 3), 1);

    // R6 clean of a resident dirty line
    cpu(2'd0, 8'h64, 8'h00, 1);
    cpu(2'd1, 8'h60, 8'hC3, 1);
    wb0 = wb_n;
    clean(8'h61);
    cpu(2'd0, 8'h68, 8'h00, 1);
    chk(wb_n == wb0, "R6 cleaned victim not written back", wb_n - wb0, 0);
    c0 = cn;
    cpu(2'd0, 8'h64, 8'h00, 1);
    chk(cn == c0, "R6 other way still resident", cn - c0, 0);
    cpu(2'd0, 8'h60, 8'h00, 1);

    // R7 clean of a non-resident line is dropped
    cpu(2'd0, 8'h74, 8'h00, 1);
    cpu(2'd1, 8'h70, 8'h5C, 1);
    wb0 = wb_n;
    clean(8'hF0);
    cpu(2'd0, 8'h78, 8'h00, 1);
    cpu(2'd0, 8'h7C, 8'h00, 1);
    chk(wb_n - wb0 == 1, "R7 dirty line still written back", wb_n - wb0, 1);
    cpu(2'd0, 8'h70, 8'h00, 1);

    // R8 full FIFO stalls a reference store
    cpu(2'd1, 8'h40, 8'h00, 1);
    cmd_ready = 1'b0;
    cpu(2'd2, 8'h40, 8'h51, 0);
    cpu(2'd2, 8'h40, 8'h52, 0);
    fork
      cpu(2'd2, 8'h40, 8'h53, 0);
      begin
        repeat (6) @(negedge clk);
        chk(req_ready == 0, "R8 stall while FIFO lacks room", req_ready, 0);
        chk(cmd_valid == 1, "R8 commands held", cmd_valid, 1);
        cmd_ready = 1'b1;
      end
    join
    sync_chk();
    cpu(2'd0, 8'h40, 8'h00, 1);

    // R5 memory image equals written-back lines
    for (int i = 0; i < 8; i++) cpu(2'd0, 8'(8'hC0 + i * 2), 8'h00, 1);
    for (int a = 0; a < 256; a++)
      chk(phys[a] == gold[a], "R5 memory image", phys[a], gold[a]);

    finished = 1;
    summary();
    $finish;
  end
endmodule